// File: doc/BRIEF.md
# Delayed Read Lead-Off Wait-State Policy

This block sits on the target side of a bridge that serves upstream memory reads as delayed transactions. A read is queued inside the bridge. The requesting master is retried and later comes back to repeat the cycle. On each return the block decides how to answer. If the completion data is ready, it grants at once. If the read has only just been queued, it tells the master to retry. If the read has been waiting long enough that its data should come soon, it holds the master with a bounded run of wait states.

An internal age counter measures how long the read has been queued. It starts on the enqueue pulse, saturates at its top value, and clears when the completion is handed over or the request is discarded. A 32-bit policy register holds a 6-bit threshold, in clocks, at bits 13:8. All other bits of that register read as zero. A threshold of zero switches the wait-state behaviour off. The total target latency of one cycle is capped at 16 clocks, counted from the clock in which the master starts. The bus protocol engine, the data path and the completion storage are outside this block.

Top module: `rd_leadoff_ctl`

## Requirements
- R1: After reset the policy register reads 0x00001200, which is a threshold of 18, and `trdy_go`, `stop_go` and `wait_req` are all low.
- R2: A write changes only bits 13:8 of the policy register. Every other bit always reads 0, so writing 0xFFFFFFFF reads back as 0x00003F00.
- R3: Suppose `mst_start` is sampled outside a hold run while `cpl_avail` is high. Then `trdy_go` is high in the next cycle with no wait state, whatever the age.
- R4: Suppose `mst_start` is sampled with no data and a nonzero threshold T. If the age is below T, `stop_go` is high in the next cycle. The age is d when `mst_start` is high d cycles after the cycle in which `req_enq` was high.
- R5: Under the same conditions, if the age is at least T, `wait_req` goes high in the next cycle and a hold run begins.
- R6: If `cpl_avail` is sampled high during a hold run, `trdy_go` is high in the next cycle and `wait_req` drops.
- R7: If no data arrives, a hold run covers cycles 1 to 15 after the start. `stop_go` is high in cycle 16.
- R8: With a threshold of 0, a start without data always gives `stop_go` in the next cycle, however old the request is.
- R9: The age saturates at 63 and does not wrap. With T = 63, a start 100 cycles after enqueue still begins a hold run.
- R10: The age clears when a grant is issued or when `req_drop` is sampled high. A later start with no new enqueue and no data then gives `stop_go`, even with T = 1.
- R11: At most one of `trdy_go` (bit 2), `stop_go` (bit 1) and `wait_req` (bit 0) is high in any cycle. A grant or retry lasts one cycle, after which all three return low.
- R12: A `mst_start` pulse that arrives during a hold run has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Policy register write strobe |
| cfg_wdata | input | 32 | Policy register write data |
| cfg_rdata | output | 32 | Policy register contents |
| req_enq | input | 1 | One-cycle pulse: upstream read queued internally |
| req_drop | input | 1 | One-cycle pulse: queued request discarded |
| cpl_avail | input | 1 | Completion data present for the pending read |
| mst_start | input | 1 | One-cycle pulse: master begins the repeat cycle |
| trdy_go | output | 1 | Grant the data phase (assert TRDY#) |
| stop_go | output | 1 | Retry the cycle (assert STOP#) |
| wait_req | output | 1 | Insert a wait state this clock |

## Verification
The properties assume the following about the inputs:
- `mst_start` is a one-cycle pulse, and each repeat attempt has exactly one of them.
- `req_drop` never falls inside a hold run.
- No new start coincides with a grant.

Under these assumptions, a cycle with `wait_req` high marks the sequencer as busy, and the checker can link each start to its answer. The stimulus keeps at most one request in flight and restarts its age with a fresh enqueue before each scenario. It raises `cpl_avail` only for the clocks it intends to be seen, and it lets every answer drain to idle before the next start.

// File: rtl/dlrd_pkg.sv
package dlrd_pkg;

    localparam int unsigned POL_W      = 32;
    localparam int unsigned THR_LSB    = 8;
    localparam int unsigned THR_W      = 6;
    localparam int unsigned LAT_CAP    = 16;
    localparam logic [31:0] POL_RST    = 32'h0000_1200;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_HOLD = 1'b1
    } phase_e;

    typedef struct packed {
        logic grant;
        logic retry;
        logic hold;
    } resp_t;

    function automatic resp_t resp_none();
        resp_t r;
        r.grant = 1'b0;
        r.retry = 1'b0;
        r.hold  = 1'b0;
        return r;
    endfunction

    function automatic resp_t resp_make(input logic g, input logic r, input logic h);
        resp_t o;
        o.grant = g;
        o.retry = r;
        o.hold  = h;
        return o;
    endfunction

endpackage

// File: rtl/dlrd_policy_reg.sv
module dlrd_policy_reg #(
    parameter int unsigned REG_W   = dlrd_pkg::POL_W,
    parameter int unsigned FLD_LSB = dlrd_pkg::THR_LSB,
    parameter int unsigned FLD_W   = dlrd_pkg::THR_W,
    parameter logic [REG_W-1:0] RST_VAL = REG_W'(dlrd_pkg::POL_RST)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic [FLD_W-1:0] thr
);
    localparam int unsigned FLD_MSB = FLD_LSB + FLD_W - 1;

    logic [REG_W-1:0] bits;

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (b >= FLD_LSB && b <= FLD_MSB) begin : g_rw
            logic q;
            always_ff @(posedge clk) begin
                if (rst)        q <= RST_VAL[b];
                else if (wr_en) q <= wr_data[b];
            end
            assign bits[b] = q;
        end else begin : g_ro
            logic unused_wbit;
            assign unused_wbit = wr_data[b];
            assign bits[b]     = 1'b0;
        end
    end

    assign rd_data = bits;
    assign thr     = bits[FLD_LSB +: FLD_W];

endmodule

// File: rtl/dlrd_age_tracker.sv
module dlrd_age_tracker #(
    parameter int unsigned AGE_W = dlrd_pkg::THR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enq,
    input  logic             clr,
    input  logic [AGE_W-1:0] thr,
    output logic             past_thr
);
    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};
    localparam logic [AGE_W-1:0] AGE_ONE = AGE_W'(1);

    logic             live_q;
    logic [AGE_W-1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= 1'b0;
            age_q  <= '0;
        end else if (enq) begin
            live_q <= 1'b1;
            age_q  <= AGE_ONE;
        end else if (clr) begin
            live_q <= 1'b0;
            age_q  <= '0;
        end else if (live_q && age_q != AGE_MAX) begin
            age_q  <= age_q + AGE_ONE;
        end
    end

    assign past_thr = live_q && (thr != '0) && (age_q >= thr);

endmodule

// File: rtl/dlrd_hold_seq.sv
module dlrd_hold_seq #(
    parameter int unsigned CAP = dlrd_pkg::LAT_CAP
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            data_rdy,
    input  logic            past_thr,
    output dlrd_pkg::resp_t resp,
    output logic            deliver
);
    import dlrd_pkg::*;

    localparam int unsigned LAT_W = $clog2(CAP);
    localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(CAP - 1);
    localparam logic [LAT_W-1:0] LAT_ONE  = LAT_W'(1);

    phase_e           ph_q, ph_d;
    logic [LAT_W-1:0] lat_q, lat_d;
    resp_t            resp_q, resp_d;

    always_comb begin
        ph_d   = ph_q;
        lat_d  = lat_q;
        resp_d = resp_none();
        unique case (ph_q)
            PH_IDLE: begin
                if (start) begin
                    if (data_rdy) begin
                        resp_d = resp_make(1'b1, 1'b0, 1'b0);
                    end else if (past_thr) begin
                        resp_d = resp_make(1'b0, 1'b0, 1'b1);
                        ph_d   = PH_HOLD;
                        lat_d  = LAT_ONE;
                    end else begin
                        resp_d = resp_make(1'b0, 1'b1, 1'b0);
                    end
                end
            end
            PH_HOLD: begin
                if (data_rdy) begin
                    resp_d = resp_make(1'b1, 1'b0, 1'b0);
                    ph_d   = PH_IDLE;
                    lat_d  = '0;
                end else if (lat_q == LAT_LAST) begin
                    resp_d = resp_make(1'b0, 1'b1, 1'b0);
                    ph_d   = PH_IDLE;
                    lat_d  = '0;
                end else begin
                    resp_d = resp_make(1'b0, 1'b0, 1'b1);
                    lat_d  = lat_q + LAT_ONE;
                end
            end
            default: begin
                ph_d  = PH_IDLE;
                lat_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            lat_q  <= '0;
            resp_q <= resp_none();
        end else begin
            ph_q   <= ph_d;
            lat_q  <= lat_d;
            resp_q <= resp_d;
        end
    end

    assign resp    = resp_q;
    assign deliver = resp_d.grant;

endmodule

// File: rtl/rd_leadoff_ctl.sv
module rd_leadoff_ctl #(
    parameter int unsigned REG_W   = dlrd_pkg::POL_W,
    parameter int unsigned THR_LSB = dlrd_pkg::THR_LSB,
    parameter int unsigned THR_W   = dlrd_pkg::THR_W,
    parameter int unsigned LAT_CAP = dlrd_pkg::LAT_CAP,
    parameter logic [REG_W-1:0] REG_RST = REG_W'(dlrd_pkg::POL_RST)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             req_enq,
    input  logic             req_drop,
    input  logic             cpl_avail,
    input  logic             mst_start,
    output logic             trdy_go,
    output logic             stop_go,
    output logic             wait_req
);
    logic [THR_W-1:0] thr;
    logic             past_thr;
    logic             deliver;
    dlrd_pkg::resp_t  resp;

    dlrd_policy_reg #(
        .REG_W   (REG_W),
        .FLD_LSB (THR_LSB),
        .FLD_W   (THR_W),
        .RST_VAL (REG_RST)
    ) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .rd_data (cfg_rdata),
        .thr     (thr)
    );

    dlrd_age_tracker #(
        .AGE_W (THR_W)
    ) u_age (
        .clk      (clk),
        .rst      (rst),
        .enq      (req_enq),
        .clr      (deliver | req_drop),
        .thr      (thr),
        .past_thr (past_thr)
    );

    dlrd_hold_seq #(
        .CAP (LAT_CAP)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (mst_start),
        .data_rdy (cpl_avail),
        .past_thr (past_thr),
        .resp     (resp),
        .deliver  (deliver)
    );

    assign trdy_go  = resp.grant;
    assign stop_go  = resp.retry;
    assign wait_req = resp.hold;

endmodule

// File: rtl/rd_leadoff_ctl_chk.sv
module rd_leadoff_ctl_chk #(
    parameter int unsigned REG_W   = 32,
    parameter int unsigned THR_LSB = 8,
    parameter int unsigned THR_W   = 6,
    parameter int unsigned LAT_CAP = 16,
    parameter logic [REG_W-1:0] REG_RST = 32'h0000_1200
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic [REG_W-1:0] cfg_wdata,
    input logic [REG_W-1:0] cfg_rdata,
    input logic             cpl_avail,
    input logic             mst_start,
    input logic             trdy_go,
    input logic             stop_go,
    input logic             wait_req
);
    localparam int unsigned RUN_W = $clog2(LAT_CAP) + 2;
    localparam logic [REG_W-1:0] FLD_MASK = REG_W'(((64'd1 << THR_W) - 64'd1) << THR_LSB);

    logic [RUN_W-1:0] wrun_q;

    always_ff @(posedge clk) begin
        if (rst)           wrun_q <= '0;
        else if (wait_req) wrun_q <= wrun_q + RUN_W'(1);
        else               wrun_q <= '0;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (cfg_rdata == REG_RST) && !trdy_go && !stop_go && !wait_req);

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata & ~FLD_MASK) == '0);

    assert_field_write_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> cfg_rdata[THR_LSB +: THR_W] == $past(cfg_wdata[THR_LSB +: THR_W]));

    assert_data_grants_R3: assert property (@(posedge clk) disable iff (rst)
        (!wait_req && mst_start && cpl_avail) |=> trdy_go);

    assert_hold_grant_R6: assert property (@(posedge clk) disable iff (rst)
        (wait_req && cpl_avail) |=> (trdy_go && !wait_req));

    assert_hold_cap_R7: assert property (@(posedge clk) disable iff (rst)
        wait_req |-> (wrun_q < RUN_W'(LAT_CAP - 1)));

    assert_thr_off_R8: assert property (@(posedge clk) disable iff (rst)
        (!wait_req && mst_start && !cpl_avail && cfg_rdata[THR_LSB +: THR_W] == '0) |=> stop_go);

    assert_resp_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({trdy_go, stop_go, wait_req}));

    assert_grant_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        (trdy_go && !mst_start) |=> !trdy_go);

    assert_retry_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        (stop_go && !mst_start) |=> !stop_go);

    assert_start_ignored_R12: assert property (@(posedge clk) disable iff (rst)
        (wait_req && mst_start && !cpl_avail) |=> (wait_req || stop_go));

endmodule

bind rd_leadoff_ctl rd_leadoff_ctl_chk #(
    .REG_W   (REG_W),
    .THR_LSB (THR_LSB),
    .THR_W   (THR_W),
    .LAT_CAP (LAT_CAP),
    .REG_RST (REG_RST)
) chk_i (.*);

// File: tb/rd_leadoff_ctl_tb_top.sv
`timescale 1ns/1ps
module rd_leadoff_ctl_tb_top;

    typedef struct {
        int         cyc;
        logic [2:0] v;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_enq = 1'b0;
    logic        req_drop = 1'b0;
    logic        cpl_avail = 1'b0;
    logic        mst_start = 1'b0;
    logic        trdy_go, stop_go, wait_req;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sbq[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    rd_leadoff_ctl dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .req_enq   (req_enq),
        .req_drop  (req_drop),
        .cpl_avail (cpl_avail),
        .mst_start (mst_start),
        .trdy_go   (trdy_go),
        .stop_go   (stop_go),
        .wait_req  (wait_req)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Monitor: pops expectations due in the current cycle and compares {trdy,stop,wait}.
    always @(negedge clk) begin
        exp_t e;
        if (!rst) begin
            while (sbq.size() != 0 && sbq[0].cyc <= cyc) begin
                e = sbq.pop_front();
                check({trdy_go, stop_go, wait_req} === e.v, e.tag,
                      {29'd0, trdy_go, stop_go, wait_req}, {29'd0, e.v});
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input int from, input int to, input logic [2:0] v, input string tag);
        for (int c = from; c <= to; c++) sbq.push_back('{c, v, tag});
    endtask

    task automatic drain();
        while (sbq.size() != 0) tick(1);
    endtask

    task automatic start_pulse();
        mst_start = 1'b1;
        tick(1);
        mst_start = 1'b0;
    endtask

    task automatic enq_age(input int d);
        req_enq = 1'b1;
        tick(1);
        req_enq = 1'b0;
        if (d > 1) tick(d - 1);
    endtask

    task automatic wr(input logic [31:0] v);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        tick(1);
        cfg_we    = 1'b0;
    endtask

    initial begin
        int m;
        tick(4);
        rst = 1'b0;
        tick(1);
        // R1: reset state
        check(cfg_rdata === 32'h0000_1200, "R1", cfg_rdata, 32'h0000_1200);
        check({trdy_go, stop_go, wait_req} === 3'b000, "R1",
              {29'd0, trdy_go, stop_go, wait_req}, 32'd0);

        // R4: young request, default threshold 18
        enq_age(5);
        m = cyc;
        push(m + 1, m + 1, 3'b010, "R4");
        push(m + 2, m + 2, 3'b000, "R11");
        start_pulse();
        drain();

        // R5, R7, R12: hold run to the cap, extra start ignored
        enq_age(18);
        m = cyc;
        push(m + 1, m + 1, 3'b001, "R5");
        push(m + 2, m + 3, 3'b001, "R7");
        push(m + 4, m + 5, 3'b001, "R12");
        push(m + 6, m + 15, 3'b001, "R7");
        push(m + 16, m + 16, 3'b010, "R7");
        push(m + 17, m + 17, 3'b000, "R11");
        start_pulse();
        tick(2);
        start_pulse();
        drain();

        // R6: data arrives during the hold run
        enq_age(20);
        m = cyc;
        push(m + 1, m + 4, 3'b001, "R6");
        push(m + 5, m + 5, 3'b100, "R6");
        push(m + 6, m + 6, 3'b000, "R6");
        start_pulse();
        tick(3);
        cpl_avail = 1'b1;
        tick(1);
        cpl_avail = 1'b0;
        drain();

        // R10: age cleared by the grant
        wr(32'h0000_0100);
        tick(3);
        m = cyc;
        push(m + 1, m + 1, 3'b010, "R10");
        start_pulse();
        drain();

        // R3: data ready on a young request
        wr(32'h0000_1200);
        enq_age(2);
        cpl_avail = 1'b1;
        m = cyc;
        push(m + 1, m + 1, 3'b100, "R3");
        push(m + 2, m + 2, 3'b000, "R11");
        start_pulse();
        cpl_avail = 1'b0;
        drain();

        // R2, R8: only the field is writable; threshold 0 disables holding
        wr(32'hFFFF_C0FF);
        check(cfg_rdata === 32'h0000_0000, "R2", cfg_rdata, 32'h0000_0000);
        enq_age(40);
        m = cyc;
        push(m + 1, m + 1, 3'b010, "R8");
        start_pulse();
        drain();

        // R2, R9: full field, saturating age
        wr(32'hFFFF_FFFF);
        check(cfg_rdata === 32'h0000_3F00, "R2", cfg_rdata, 32'h0000_3F00);
        enq_age(100);
        m = cyc;
        push(m + 1, m + 2, 3'b001, "R9");
        push(m + 3, m + 3, 3'b100, "R9");
        start_pulse();
        tick(1);
        cpl_avail = 1'b1;
        tick(1);
        cpl_avail = 1'b0;
        drain();

        // R10: discard clears the age
        wr(32'h0000_0100);
        enq_age(3);
        req_drop = 1'b1;
        tick(1);
        req_drop = 1'b0;
        m = cyc;
        push(m + 1, m + 1, 3'b010, "R10");
        start_pulse();
        drain();

        // R4/R5 boundary at threshold 4
        wr(32'h0000_0400);
        enq_age(3);
        m = cyc;
        push(m + 1, m + 1, 3'b010, "R4");
        start_pulse();
        drain();
        enq_age(4);
        m = cyc;
        push(m + 1, m + 1, 3'b001, "R5");
        push(m + 2, m + 2, 3'b100, "R6");
        start_pulse();
        cpl_avail = 1'b1;
        tick(1);
        cpl_avail = 1'b0;
        drain();

        // R3: data ready on an old request, no wait state
        enq_age(30);
        cpl_avail = 1'b1;
        m = cyc;
        push(m + 1, m + 1, 3'b100, "R3");
        push(m + 2, m + 2, 3'b000, "R11");
        start_pulse();
        cpl_avail = 1'b0;
        drain();

        tick(2);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule